// File: doc/BRIEF.md
# Big-Endian Pipelined Load/Store Bus Unit

This unit connects a processor core's memory stage to a pipelined Wishbone master port. The core presents one request at a time: a byte address, an access width code, store data, a direction flag and a destination register tag. The unit turns it into a word address and four byte-lane selects. Byte lanes are numbered big-endian. Store data is steered onto the lanes that the select marks. Load data is pulled from the addressed lanes, right-justified and zero-extended, and handed back with the tag that came with the request.

Requests stream onto the bus without waiting for earlier acknowledgements, so a burst of loads overlaps. An in-order record of every request on the bus is kept and is popped as acknowledgements return. The cycle line stays asserted until the last acknowledgement has arrived. A width/alignment violation is refused locally with a one-clock flag and never reaches the bus. A bus error response aborts the whole cycle and raises its own one-clock flag.

Top module: `bel_lsu`

## Requirements
- R1: The bus word address `wb_adr` equals byte address bits 31:2. Address bits 1:0 affect only the selects and the data lanes.
- R2: Width codes are 0 = byte, 1 = half-word and 2 = word. A byte at offset k drives select bit 3-k. A half-word at offset 0 selects 4'b1100 and at offset 2 selects 4'b0011. A word selects 4'b1111.
- R3: Store data is placed big-endian. A byte goes on bits [31-8k -: 8] for offset k. A half-word goes on bits 31:16 at offset 0 and bits 15:0 at offset 2. A word is passed unchanged. Unselected lanes are zero.
- R4: A load returns the addressed lanes on `rsp_data`, right-justified and zero-extended, using the same lane map as R3.
- R5: A half-word with address bit 0 set, a word with either low address bit set, or width code 3 is consumed without any bus request. `misalign_err` is high for exactly the clock after acceptance.
- R6: `wb_stb` is never high while `wb_cyc` is low.
- R7: Requests go out back to back without waiting for acknowledgements. At most 4 requests (on the bus or waiting to be taken) are outstanding, and `req_ready` is low while 4 are outstanding.
- R8: While `wb_stb` and `wb_stall` are both high, the address, select, write-enable and write data stay unchanged in the next clock.
- R9: `wb_cyc` stays high while any issued request is unacknowledged. It is low in the clock after the final acknowledgement unless a new request was issued in that same clock.
- R10: Each load acknowledgement gives one `rsp_valid` pulse in the following clock. Pulses come in issue order and carry the request's tag. Store acknowledgements give no pulse.
- R11: An error response during a cycle drops `wb_cyc` and `wb_stb` in the next clock and pulses `bus_err` for one clock. No response is produced for the failed request or for any other request still outstanding.
- R12: While a cycle is open, a request of the opposite direction is held (`req_ready` low) until the cycle closes, so `wb_we` is constant within a cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Core presents a request |
| req_we | input | 1 | 1 = store, 0 = load |
| req_size | input | 2 | Width code: 0 byte, 1 half-word, 2 word |
| req_addr | input | 32 | Byte address |
| req_wdata | input | 32 | Store value, right-justified |
| req_tag | input | 5 | Destination register tag |
| req_ready | output | 1 | Request accepted this clock when high with req_valid |
| misalign_err | output | 1 | One-clock flag for a refused request |
| rsp_valid | output | 1 | Load result valid |
| rsp_data | output | 32 | Zero-extended load result |
| rsp_tag | output | 5 | Tag of the returned load |
| bus_err | output | 1 | One-clock flag after a bus error response |
| wb_cyc | output | 1 | Bus cycle |
| wb_stb | output | 1 | Bus strobe |
| wb_we | output | 1 | Bus write enable |
| wb_adr | output | 30 | Bus word address |
| wb_sel | output | 4 | Byte-lane selects, bit 3 = lowest address |
| wb_dat_o | output | 32 | Bus write data |
| wb_stall | input | 1 | Slave cannot take the strobe |
| wb_ack | input | 1 | Slave acknowledgement |
| wb_err | input | 1 | Slave error response |
| wb_dat_i | input | 32 | Bus read data |

## Verification
The tightest overlap is an acknowledgement that retires the last outstanding request in the same clock that a new request is accepted. The cycle must then stay open with the count unchanged, instead of closing and reopening. Random back-to-back traffic, with random slave stalls and latencies of one to three clocks, makes this happen repeatedly. Each time a drained edge leaves no strobe pending, `wb_cyc` is checked low, and it is checked high whenever the bench's own count of unacknowledged requests is nonzero. The second overlap is an error response arriving while later requests are already on the bus. A directed burst provokes it, and the bench expects exactly one `bus_err` pulse and no load result from the burst.

// File: rtl/lsu_pkg.sv
package lsu_pkg;

    localparam int ADDR_W = 32;
    localparam int DATA_W = 32;
    localparam int LANES  = DATA_W / 8;
    localparam int WADR_W = ADDR_W - 2;
    localparam int TAG_W  = 5;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_BAD  = 2'd3
    } size_e;

    typedef struct packed {
        logic [TAG_W-1:0] tag;
        size_e            size;
        logic [1:0]       off;
        logic             we;
    } meta_t;

    function automatic logic misaligned(size_e s, logic [1:0] off);
        case (s)
            SZ_BYTE: return 1'b0;
            SZ_HALF: return off[0];
            SZ_WORD: return |off;
            default: return 1'b1;
        endcase
    endfunction

    // lane i covers data bits [8i+7:8i]; byte offset 0 is the top lane
    function automatic logic [LANES-1:0] lane_mask(size_e s, logic [1:0] off);
        case (s)
            SZ_BYTE: return 4'b1000 >> off;
            SZ_HALF: return off[1] ? 4'b0011 : 4'b1100;
            default: return 4'b1111;
        endcase
    endfunction

    function automatic logic [DATA_W-1:0] lane_data(size_e s, logic [1:0] off,
                                                    logic [DATA_W-1:0] d);
        logic [DATA_W-1:0] r;
        logic [LANES-1:0]  m;
        r = '0;
        m = lane_mask(s, off);
        for (int i = 0; i < LANES; i++) begin
            if (m[i]) begin
                case (s)
                    SZ_BYTE: r[i*8 +: 8] = d[7:0];
                    SZ_HALF: r[i*8 +: 8] = (i % 2 == 1) ? d[15:8] : d[7:0];
                    default: r[i*8 +: 8] = d[i*8 +: 8];
                endcase
            end
        end
        return r;
    endfunction

    function automatic logic [DATA_W-1:0] lane_extract(size_e s, logic [1:0] off,
                                                       logic [DATA_W-1:0] d);
        logic [DATA_W-1:0] sh;
        sh = d >> {~off, 3'b000};
        case (s)
            SZ_BYTE: return {24'b0, sh[7:0]};
            SZ_HALF: return off[1] ? {16'b0, d[15:0]} : {16'b0, d[31:16]};
            default: return d;
        endcase
    endfunction

endpackage

// File: rtl/lsu_issue.sv
module lsu_issue
    import lsu_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              take_i,
    input  logic              we_i,
    input  logic [1:0]        size_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic [TAG_W-1:0]  tag_i,
    input  logic              flush_i,
    input  logic              stall_i,
    output logic              push_o,
    output meta_t             meta_o,
    output logic              stb_o,
    output logic              we_o,
    output logic [WADR_W-1:0] adr_o,
    output logic [LANES-1:0]  sel_o,
    output logic [DATA_W-1:0] dat_o,
    output logic              bad_o
);

    size_e sz;
    logic  bad;
    logic              stb_q, we_q, bad_q;
    logic [WADR_W-1:0] adr_q;
    logic [LANES-1:0]  sel_q;
    logic [DATA_W-1:0] dat_q;

    assign sz     = size_e'(size_i);
    assign bad    = misaligned(sz, addr_i[1:0]);
    assign push_o = take_i && !bad;
    assign meta_o = '{tag: tag_i, size: sz, off: addr_i[1:0], we: we_i};

    always_ff @(posedge clk) begin
        if (rst) begin
            stb_q <= 1'b0;
            we_q  <= 1'b0;
            adr_q <= '0;
            sel_q <= '0;
            dat_q <= '0;
            bad_q <= 1'b0;
        end else begin
            bad_q <= take_i && bad;
            if (flush_i) begin
                stb_q <= 1'b0;
            end else if (push_o) begin
                stb_q <= 1'b1;
                we_q  <= we_i;
                adr_q <= addr_i[ADDR_W-1:2];
                sel_q <= lane_mask(sz, addr_i[1:0]);
                dat_q <= we_i ? lane_data(sz, addr_i[1:0], wdata_i) : '0;
            end else if (!stall_i) begin
                stb_q <= 1'b0;
            end
        end
    end

    assign stb_o = stb_q;
    assign we_o  = we_q;
    assign adr_o = adr_q;
    assign sel_o = sel_q;
    assign dat_o = dat_q;
    assign bad_o = bad_q;

    assert_hold_on_stall_R8: assert property (@(posedge clk) disable iff (rst)
        stb_q && stall_i && !flush_i |=> stb_q && $stable(adr_q) && $stable(sel_q)
                                         && $stable(dat_q) && $stable(we_q));

    assert_reject_flag_R5: assert property (@(posedge clk) disable iff (rst)
        take_i && bad |=> bad_q);

    assert_reject_no_bus_R5: assert property (@(posedge clk) disable iff (rst)
        take_i && bad && !stb_q |=> !stb_q);

endmodule

// File: rtl/lsu_track.sv
module lsu_track
    import lsu_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         push_i,
    input  meta_t                        meta_i,
    input  logic                         ack_i,
    input  logic                         err_i,
    output logic                         cyc_o,
    output logic                         pop_o,
    output logic                         flush_o,
    output meta_t                        head_o,
    output logic [$clog2(DEPTH+1)-1:0]   occ_o,
    output logic                         berr_o
);

    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    meta_t             q [DEPTH];
    logic [PTR_W-1:0]  wr_q, rd_q;
    logic [CNT_W-1:0]  occ_q, occ_nx;
    logic              cyc_q, berr_q;

    function automatic logic [PTR_W-1:0] bump(logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign pop_o   = ack_i && cyc_q;
    assign flush_o = err_i && cyc_q;
    assign occ_nx  = occ_q + CNT_W'(push_i) - CNT_W'(pop_o);

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_q   <= '0;
            rd_q   <= '0;
            occ_q  <= '0;
            cyc_q  <= 1'b0;
            berr_q <= 1'b0;
        end else begin
            berr_q <= flush_o;
            if (flush_o) begin
                wr_q  <= '0;
                rd_q  <= '0;
                occ_q <= '0;
                cyc_q <= 1'b0;
            end else begin
                if (push_i) wr_q <= bump(wr_q);
                if (pop_o)  rd_q <= bump(rd_q);
                occ_q <= occ_nx;
                cyc_q <= (occ_nx != '0);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (push_i && !flush_o) q[wr_q] <= meta_i;
    end

    assign head_o = q[rd_q];
    assign cyc_o  = cyc_q;
    assign occ_o  = occ_q;
    assign berr_o = berr_q;

    assert_occ_bound_R7: assert property (@(posedge clk) disable iff (rst)
        occ_q <= CNT_W'(DEPTH));

    assert_err_closes_R11: assert property (@(posedge clk) disable iff (rst)
        flush_o |=> !cyc_q && berr_q);

    assert_busy_keeps_cyc_R9: assert property (@(posedge clk) disable iff (rst)
        cyc_q && !pop_o && !flush_o |=> cyc_q);

endmodule

// File: rtl/lsu_return.sv
module lsu_return
    import lsu_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              pop_i,
    input  meta_t             head_i,
    input  logic [DATA_W-1:0] bus_dat_i,
    output logic              rsp_valid_o,
    output logic [DATA_W-1:0] rsp_data_o,
    output logic [TAG_W-1:0]  rsp_tag_o
);

    logic              v_q;
    logic [DATA_W-1:0] d_q;
    logic [TAG_W-1:0]  t_q;
    logic              is_load;

    assign is_load = pop_i && !head_i.we;

    always_ff @(posedge clk) begin
        if (rst) begin
            v_q <= 1'b0;
            d_q <= '0;
            t_q <= '0;
        end else begin
            v_q <= is_load;
            if (is_load) begin
                d_q <= lane_extract(head_i.size, head_i.off, bus_dat_i);
                t_q <= head_i.tag;
            end
        end
    end

    assign rsp_valid_o = v_q;
    assign rsp_data_o  = d_q;
    assign rsp_tag_o   = t_q;

    assert_store_silent_R10: assert property (@(posedge clk) disable iff (rst)
        pop_i && head_i.we |=> !v_q);

    assert_byte_zero_ext_R4: assert property (@(posedge clk) disable iff (rst)
        is_load && head_i.size == SZ_BYTE |=> v_q && (d_q[31:8] == '0));

endmodule

// File: rtl/bel_lsu.sv
module bel_lsu
    import lsu_pkg::*;
#(
    parameter int MAX_OUT = 4
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        req_valid,
    input  logic        req_we,
    input  logic [1:0]  req_size,
    input  logic [31:0] req_addr,
    input  logic [31:0] req_wdata,
    input  logic [4:0]  req_tag,
    output logic        req_ready,
    output logic        misalign_err,
    output logic        rsp_valid,
    output logic [31:0] rsp_data,
    output logic [4:0]  rsp_tag,
    output logic        bus_err,
    output logic        wb_cyc,
    output logic        wb_stb,
    output logic        wb_we,
    output logic [29:0] wb_adr,
    output logic [3:0]  wb_sel,
    output logic [31:0] wb_dat_o,
    input  logic        wb_stall,
    input  logic        wb_ack,
    input  logic        wb_err,
    input  logic [31:0] wb_dat_i
);

    localparam int CNT_W = $clog2(MAX_OUT + 1);

    logic             take, push, pop, flush;
    meta_t            meta_new, head;
    logic [CNT_W-1:0] occ;

    assign req_ready = !(wb_stb && wb_stall)
                    && (occ < CNT_W'(MAX_OUT))
                    && !(wb_cyc && wb_err)
                    && (!wb_cyc || (req_we == wb_we));
    assign take = req_valid && req_ready;

    lsu_issue u_issue (
        .clk     (clk),
        .rst     (rst),
        .take_i  (take),
        .we_i    (req_we),
        .size_i  (req_size),
        .addr_i  (req_addr),
        .wdata_i (req_wdata),
        .tag_i   (req_tag),
        .flush_i (flush),
        .stall_i (wb_stall),
        .push_o  (push),
        .meta_o  (meta_new),
        .stb_o   (wb_stb),
        .we_o    (wb_we),
        .adr_o   (wb_adr),
        .sel_o   (wb_sel),
        .dat_o   (wb_dat_o),
        .bad_o   (misalign_err)
    );

    lsu_track #(.DEPTH(MAX_OUT)) u_track (
        .clk     (clk),
        .rst     (rst),
        .push_i  (push),
        .meta_i  (meta_new),
        .ack_i   (wb_ack),
        .err_i   (wb_err),
        .cyc_o   (wb_cyc),
        .pop_o   (pop),
        .flush_o (flush),
        .head_o  (head),
        .occ_o   (occ),
        .berr_o  (bus_err)
    );

    lsu_return u_return (
        .clk         (clk),
        .rst         (rst),
        .pop_i       (pop),
        .head_i      (head),
        .bus_dat_i   (wb_dat_i),
        .rsp_valid_o (rsp_valid),
        .rsp_data_o  (rsp_data),
        .rsp_tag_o   (rsp_tag)
    );

    assert_stb_within_cyc_R6: assert property (@(posedge clk) disable iff (rst)
        wb_stb |-> wb_cyc);

    assert_full_blocks_R7: assert property (@(posedge clk) disable iff (rst)
        occ == CNT_W'(MAX_OUT) |-> !req_ready);

    assert_dir_constant_R12: assert property (@(posedge clk) disable iff (rst)
        wb_cyc |=> (wb_cyc |-> $stable(wb_we)));

endmodule

// File: tb/bel_lsu_test.sv
module bel_lsu_test;
    import lsu_pkg::*;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #5 clk = ~clk;

    logic        req_valid = 0, req_we = 0;
    logic [1:0]  req_size = 0;
    logic [31:0] req_addr = 0, req_wdata = 0;
    logic [4:0]  req_tag = 0;
    logic        req_ready, misalign_err, rsp_valid, bus_err;
    logic [31:0] rsp_data;
    logic [4:0]  rsp_tag;
    logic        wb_cyc, wb_stb, wb_we;
    logic [29:0] wb_adr;
    logic [3:0]  wb_sel;
    logic [31:0] wb_dat_o;
    logic        s_stall, s_ack, s_err;
    logic [31:0] s_dat;

    bel_lsu #(.MAX_OUT(4)) uut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_we(req_we),
        .req_size(req_size), .req_addr(req_addr), .req_wdata(req_wdata),
        .req_tag(req_tag), .req_ready(req_ready), .misalign_err(misalign_err),
        .rsp_valid(rsp_valid), .rsp_data(rsp_data), .rsp_tag(rsp_tag),
        .bus_err(bus_err), .wb_cyc(wb_cyc), .wb_stb(wb_stb), .wb_we(wb_we),
        .wb_adr(wb_adr), .wb_sel(wb_sel), .wb_dat_o(wb_dat_o),
        .wb_stall(s_stall), .wb_ack(s_ack), .wb_err(s_err), .wb_dat_i(s_dat)
    );

    int n_chk = 0, n_bad = 0;
    task automatic check(bit ok, string rq, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", rq, act, exp);
        end
    endtask

    // ---- expectation functions ----
    function automatic logic [3:0] ex_sel(logic [1:0] sz, logic [1:0] off);
        case ({sz, off})
            4'b0000: return 4'b1000;
            4'b0001: return 4'b0100;
            4'b0010: return 4'b0010;
            4'b0011: return 4'b0001;
            4'b0100: return 4'b1100;
            4'b0110: return 4'b0011;
            default: return 4'b1111;
        endcase
    endfunction

    function automatic logic [31:0] ex_wdat(logic [1:0] sz, logic [1:0] off, logic [31:0] d);
        if (sz == 2'd0) begin
            case (off)
                2'd0: return {d[7:0], 24'h0};
                2'd1: return {8'h0, d[7:0], 16'h0};
                2'd2: return {16'h0, d[7:0], 8'h0};
                default: return {24'h0, d[7:0]};
            endcase
        end
        if (sz == 2'd1) return (off == 2'd0) ? {d[15:0], 16'h0} : {16'h0, d[15:0]};
        return d;
    endfunction

    function automatic logic [31:0] ex_load(logic [1:0] sz, logic [1:0] off, logic [31:0] w);
        if (sz == 2'd0) begin
            case (off)
                2'd0: return {24'h0, w[31:24]};
                2'd1: return {24'h0, w[23:16]};
                2'd2: return {24'h0, w[15:8]};
                default: return {24'h0, w[7:0]};
            endcase
        end
        if (sz == 2'd1) return (off == 2'd0) ? {16'h0, w[31:16]} : {16'h0, w[15:0]};
        return w;
    endfunction

    function automatic bit ex_bad(logic [1:0] sz, logic [1:0] off);
        return (sz == 2'd3) || (sz == 2'd1 && off[0]) || (sz == 2'd2 && off != 2'd0);
    endfunction

    // ---- scoreboards ----
    typedef struct packed {
        logic [29:0] adr;
        logic [3:0]  sel;
        logic [31:0] dat;
        logic        we;
    } bexp_t;
    bexp_t        bq[$];
    logic [36:0]  rq[$];
    logic [31:0]  shadow [16];
    logic [31:0]  smem [16];
    int exp_mis = 0, n_mis = 0, n_berr = 0, skip_rsp = 0;
    bit skip_exp = 0;

    // ---- slave model ----
    int lat_min = 1, lat_max = 1, stall_pct = 0;
    int err_at = -1, n_acc = 0, tick = 0, bout = 0, peak = 0;
    bit drained = 0, err_seen = 0;
    logic [31:0] sq_dat [16];
    int          sq_due [16];
    bit          sq_err [16];
    int          sq_n = 0;

    always @(posedge clk) begin
        if (rst) begin
            s_ack <= 0; s_err <= 0; s_stall <= 0; s_dat <= '0;
            sq_n = 0; bout = 0;
        end else begin
            bit dec, erring;
            dec = 0; erring = 0; err_seen = 0;
            if (wb_cyc && s_err) begin bout = 0; dec = 1; err_seen = 1; end
            else if (wb_cyc && s_ack) begin bout--; dec = 1; end
            s_ack <= 0; s_err <= 0;
            if (sq_n > 0 && sq_due[0] <= tick) begin
                if (sq_err[0]) begin
                    s_err <= 1; sq_n = 0; erring = 1;
                end else begin
                    s_ack <= 1; s_dat <= sq_dat[0];
                    for (int i = 0; i < 15; i++) begin
                        sq_dat[i] = sq_dat[i+1]; sq_due[i] = sq_due[i+1]; sq_err[i] = sq_err[i+1];
                    end
                    sq_n--;
                end
            end
            if (wb_cyc && wb_stb && !s_stall && !erring) begin
                bexp_t b;
                logic [31:0] rd;
                n_acc++;
                bout++;
                if (bout > peak) peak = bout;
                if (!skip_exp) begin
                    if (bq.size() == 0) check(0, "R5 unexpected bus request", {2'b0, wb_adr}, 0);
                    else begin
                        b = bq.pop_front();
                        check(wb_adr == b.adr, "R1 word address", {2'b0, wb_adr}, {2'b0, b.adr});
                        check(wb_sel == b.sel, "R2 select lanes", {28'h0, wb_sel}, {28'h0, b.sel});
                        check(wb_we == b.we, "R12 direction", {31'h0, wb_we}, {31'h0, b.we});
                        if (b.we) check(wb_dat_o == b.dat, "R3 store lanes", wb_dat_o, b.dat);
                    end
                end
                rd = smem[wb_adr[3:0]];
                if (wb_we)
                    for (int i = 0; i < 4; i++)
                        if (wb_sel[i]) smem[wb_adr[3:0]][i*8 +: 8] = wb_dat_o[i*8 +: 8];
                sq_dat[sq_n] = rd;
                sq_due[sq_n] = tick + lat_min + int'($urandom % (lat_max - lat_min + 1));
                sq_err[sq_n] = (n_acc == err_at);
                sq_n++;
            end
            drained = dec && (bout == 0);
            s_stall <= (int'($urandom % 100) < stall_pct);
            tick++;
        end
    end

    // ---- monitors, sampled mid-cycle ----
    bit hold_prev = 0, cyc_prev = 0, we_prev = 0;
    logic [29:0] adr_prev; logic [3:0] sel_prev; logic [31:0] dat_prev;
    always @(negedge clk) begin
        if (!rst) begin
            if (misalign_err) n_mis++;
            if (bus_err) n_berr++;
            if (rsp_valid) begin
                if (skip_exp) skip_rsp++;
                else if (rq.size() == 0) check(0, "R10 unexpected response", rsp_data, 0);
                else begin
                    logic [36:0] e;
                    e = rq.pop_front();
                    check(rsp_data == e[31:0], "R4 load data", rsp_data, e[31:0]);
                    check(rsp_tag == e[36:32], "R10 tag order", {27'h0, rsp_tag}, {27'h0, e[36:32]});
                end
            end
            if (hold_prev)
                check(wb_stb && wb_adr == adr_prev && wb_sel == sel_prev && wb_dat_o == dat_prev,
                      "R8 stalled request held", {2'b0, wb_adr}, {2'b0, adr_prev});
            check(!wb_stb || wb_cyc, "R6 strobe inside cycle", {31'h0, wb_stb}, {31'h0, wb_cyc});
            if (bout > 0 && !err_seen) check(wb_cyc, "R9 cycle held", {31'h0, wb_cyc}, 1);
            if (drained && !err_seen && !wb_stb) check(!wb_cyc, "R9 cycle closes", {31'h0, wb_cyc}, 0);
            if (err_seen) begin
                check(bus_err, "R11 error flag", {31'h0, bus_err}, 1);
                check(!wb_cyc && !wb_stb, "R11 cycle aborted", {31'h0, wb_cyc}, 0);
            end
            if (wb_cyc && cyc_prev) check(wb_we == we_prev, "R12 direction constant", {31'h0, wb_we}, {31'h0, we_prev});
            hold_prev = wb_stb && s_stall && !(wb_cyc && s_err);
            adr_prev = wb_adr; sel_prev = wb_sel; dat_prev = wb_dat_o;
            cyc_prev = wb_cyc; we_prev = wb_we;
        end
    end

    // ---- driver ----
    task automatic issue(bit we, logic [1:0] sz, logic [31:0] a, logic [31:0] d, logic [4:0] tg);
        req_valid = 1; req_we = we; req_size = sz; req_addr = a; req_wdata = d; req_tag = tg;
        #1;
        while (!req_ready) begin @(negedge clk); #1; end
        if (ex_bad(sz, a[1:0])) exp_mis++;
        else if (!skip_exp) begin
            bexp_t b;
            b.adr = a[31:2]; b.sel = ex_sel(sz, a[1:0]); b.we = we;
            b.dat = ex_wdat(sz, a[1:0], d);
            bq.push_back(b);
            if (we) begin
                for (int i = 0; i < 4; i++)
                    if (b.sel[i]) shadow[a[5:2]][i*8 +: 8] = b.dat[i*8 +: 8];
            end else rq.push_back({tg, ex_load(sz, a[1:0], shadow[a[5:2]])});
        end
        @(negedge clk);
        req_valid = 0;
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL R7 run hung: actual %0d expected %0d", 1, 0);
        finish_run();
    end

    initial begin
        void'($urandom(32'd4242));
        for (int i = 0; i < 16; i++) begin
            smem[i] = 32'hA5C3_0000 ^ (i * 32'h0103_0507);
            shadow[i] = smem[i];
        end
        repeat (4) @(negedge clk);
        rst = 0;
        @(negedge clk);
        check(!wb_cyc && !wb_stb, "R9 reset idle", {31'h0, wb_cyc}, 0);
        check(!rsp_valid && !misalign_err && !bus_err, "R10 reset quiet", {31'h0, rsp_valid}, 0);
        check(req_ready, "R7 reset ready", {31'h0, req_ready}, 1);

        // byte stores at every offset, then word and half readback (R2 R3 R4)
        for (int k = 0; k < 4; k++) issue(1, 2'd0, 32'h10 + k, 32'h11 * (k + 1), 5'd0);
        issue(0, 2'd2, 32'h10, 0, 5'd1);
        issue(0, 2'd1, 32'h12, 0, 5'd2);
        issue(0, 2'd1, 32'h10, 0, 5'd3);
        for (int k = 0; k < 4; k++) issue(0, 2'd0, 32'h10 + k, 0, 5'(k + 4));
        issue(1, 2'd1, 32'h22, 32'hFFFF_BEEF, 5'd0);
        issue(0, 2'd2, 32'h20, 0, 5'd9);
        repeat (6) @(negedge clk);

        // refused requests (R5)
        issue(0, 2'd1, 32'h31, 0, 5'd0);
        check(misalign_err && !wb_stb, "R5 half misaligned", {31'h0, misalign_err}, 1);
        issue(1, 2'd2, 32'h32, 32'h1, 5'd0);
        check(misalign_err && !wb_stb, "R5 word misaligned", {31'h0, misalign_err}, 1);
        issue(0, 2'd3, 32'h30, 0, 5'd0);
        check(misalign_err && !wb_stb, "R5 bad width code", {31'h0, misalign_err}, 1);
        @(negedge clk);
        check(!misalign_err, "R5 flag one clock", {31'h0, misalign_err}, 0);

        // outstanding limit (R7)
        lat_min = 20; lat_max = 20; peak = 0;
        for (int k = 0; k < 4; k++) issue(0, 2'd2, 32'(k * 4), 0, 5'(k));
        req_valid = 1; req_we = 0; req_size = 2'd2; req_addr = 32'h10; #1;
        check(!req_ready, "R7 ready low when full", {31'h0, req_ready}, 0);
        issue(0, 2'd2, 32'h10, 0, 5'd4);
        issue(0, 2'd2, 32'h14, 0, 5'd5);
        repeat (50) @(negedge clk);
        check(peak == 4, "R7 peak outstanding", 32'(peak), 4);

        // direction change waits (R12)
        lat_min = 8; lat_max = 8;
        issue(0, 2'd2, 32'h8, 0, 5'd6);
        req_valid = 1; req_we = 1; req_size = 2'd2; req_addr = 32'h8; #1;
        check(!req_ready, "R12 store held during load cycle", {31'h0, req_ready}, 0);
        issue(1, 2'd2, 32'h8, 32'h0BAD_F00D, 5'd0);
        issue(0, 2'd2, 32'h8, 0, 5'd7);
        repeat (30) @(negedge clk);

        // bus error aborts cycle (R11)
        lat_min = 4; lat_max = 4; stall_pct = 0;
        skip_exp = 1; skip_rsp = 0; n_berr = 0;
        err_at = n_acc + 1;
        for (int k = 0; k < 3; k++) issue(0, 2'd2, 32'(k * 4), 0, 5'(k));
        repeat (15) @(negedge clk);
        skip_exp = 0; err_at = -1;
        check(skip_rsp == 0, "R11 no responses after error", 32'(skip_rsp), 0);
        check(n_berr == 1, "R11 single error pulse", 32'(n_berr), 1);
        issue(0, 2'd0, 32'h3, 0, 5'd11);
        repeat (10) @(negedge clk);

        // random traffic
        lat_min = 1; lat_max = 3; stall_pct = 25;
        for (int n = 0; n < 400; n++) begin
            logic [1:0] sz;
            sz = ($urandom % 16 == 0) ? 2'd3 : 2'($urandom % 3);
            issue(bit'($urandom % 2), sz, 32'($urandom % 64), $urandom, 5'($urandom % 32));
            if ($urandom % 4 == 0) repeat ($urandom % 3) @(negedge clk);
        end
        repeat (40) @(negedge clk);

        check(rq.size() == 0, "R10 every load answered", 32'(rq.size()), 0);
        check(bq.size() == 0, "R1 every request on bus", 32'(bq.size()), 0);
        check(n_mis == exp_mis, "R5 refused count", 32'(n_mis), 32'(exp_mis));
        check(!wb_cyc, "R9 idle at end", {31'h0, wb_cyc}, 0);
        finish_run();
    end

endmodule